// File: doc/BRIEF.md
# Read-After-Write Wait Calculator

This block works out how long one consumer operand must still wait before its value can be used, and which producer is the cause. Each request gives up to four candidate producers. A producer is either still in flight, with a remaining latency that may not yet be known, or already committed, with a cycle stamp of its write-back. Each candidate also carries a signed read-advance value, which is the forwarding offset between that producer and this consumer. A positive advance shortens the wait. A negative advance lengthens it, and it can also keep a producer that has already committed relevant for a few more cycles.

A scheduler presents the candidates together with the current cycle count and pulses `in_valid`. One cycle later the block reports the hazard: whether one exists, the register that causes it, and the remaining cycles. A producer whose latency is still unknown is reported as an unknown-length hazard. The block does not look producers up and does not schedule anything.

Top module: `raw_wait_calc`

## Requirements
- R1: For an in-flight candidate with a known latency, the wait is `cand_left - cand_adv`. `cand_left` is an 8-bit unsigned value and `cand_adv` is a 6-bit two's-complement value. Candidate i occupies bits `[i*W +: W]` of each packed vector.
- R2: An in-flight candidate takes part only when its wait is greater than zero.
- R3: Among the candidates that take part, the one with the largest wait is reported in `haz_reg` and `haz_cycles`.
- R4: When two candidates have equal waits, the one with the lower index is kept.
- R5: An in-flight candidate with `cand_unk` set produces `haz_valid=1`, `haz_unknown=1` and `haz_cycles=0`, with its register. This happens only if no candidate with a lower index has already produced a hazard. `cand_unk` is ignored on committed candidates.
- R6: Once an unknown hazard is recorded, no later candidate replaces it, whether its latency is known or unknown.
- R7: A committed candidate (`cand_done=1`) takes part only when its read advance is negative.
- R8: A committed candidate's wait is `-cand_adv - elapsed`. The candidate takes part only while elapsed is strictly less than `-cand_adv`.
- R9: Elapsed is `(now_cycle - cand_wb) mod 256`, computed on the 8-bit stamps, so the count wraps.
- R10: When no candidate takes part, the outputs are `haz_valid=0`, `haz_unknown=0`, `haz_reg=0` and `haz_cycles=0`. Candidates with `cand_vld=0` have no effect, whatever their other fields hold.
- R11: Results are registered. They appear in the cycle after `in_valid`, and `out_valid` is high for exactly that cycle. The result outputs hold between requests and are zero after reset.
- R12: In-flight and committed candidates compete for R3 and R4 under one rule, ordered by their index alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Evaluate the presented candidates |
| cand_vld | input | 4 | Candidate present |
| cand_done | input | 4 | Candidate has committed (1) or is in flight (0) |
| cand_unk | input | 4 | In-flight latency not yet known |
| cand_left | input | 32 | Remaining latency, 8 bits per candidate |
| cand_wb | input | 32 | Write-back cycle stamp, 8 bits per candidate |
| cand_adv | input | 24 | Signed read advance, 6 bits per candidate |
| cand_reg | input | 24 | Register ID, 6 bits per candidate |
| now_cycle | input | 8 | Current cycle count |
| out_valid | output | 1 | Result present this cycle |
| haz_valid | output | 1 | A hazard exists |
| haz_unknown | output | 1 | The hazard length is unknown |
| haz_reg | output | 6 | Register causing the hazard |
| haz_cycles | output | 10 | Remaining wait in cycles |

## Verification
Two functions can act in the same request: the in-flight wait, which is latency minus advance, and the committed window, which is the advance magnitude minus elapsed cycles. Their results must then be compared on one scale. The bench puts both kinds in one request, sometimes with the committed candidate winning, sometimes with the in-flight one winning, and sometimes with the two tied so that index order decides. An unknown latency placed before or after a known one tests the sticky rule. Each expected result comes from an independent integer model and is compared when it leaves the block.

// File: rtl/raw_pkg.sv
package raw_pkg;

  typedef enum logic [1:0] {
    KIND_IDLE    = 2'd0,
    KIND_FLIGHT  = 2'd1,
    KIND_UNKNOWN = 2'd2,
    KIND_COMMIT  = 2'd3
  } cand_kind_e;

  function automatic cand_kind_e classify(input logic vld, input logic done,
                                          input logic unk);
    if (!vld)      return KIND_IDLE;
    else if (done) return KIND_COMMIT;
    else if (unk)  return KIND_UNKNOWN;
    else           return KIND_FLIGHT;
  endfunction

endpackage

// File: rtl/raw_cand_eval.sv
module raw_cand_eval
  import raw_pkg::*;
#(
  parameter int LEFT_W  = 8,
  parameter int ADV_W   = 6,
  parameter int STAMP_W = 8,
  parameter int WAIT_W  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vld,
  input  logic               done,
  input  logic               unk,
  input  logic [LEFT_W-1:0]  left,
  input  logic [STAMP_W-1:0] wb,
  input  logic [ADV_W-1:0]   adv,
  input  logic [STAMP_W-1:0] now,
  output cand_kind_e         kind,
  output logic               counts,
  output logic [WAIT_W-1:0]  wait_cyc
);
  localparam int CW = LEFT_W + ADV_W + STAMP_W + 2;

  function automatic logic signed [CW-1:0] zx_left(input logic [LEFT_W-1:0] v);
    return {{(CW-LEFT_W){1'b0}}, v};
  endfunction

  function automatic logic signed [CW-1:0] zx_stamp(input logic [STAMP_W-1:0] v);
    return {{(CW-STAMP_W){1'b0}}, v};
  endfunction

  function automatic logic signed [CW-1:0] sx_adv(input logic [ADV_W-1:0] v);
    return {{(CW-ADV_W){v[ADV_W-1]}}, v};
  endfunction

  logic [STAMP_W-1:0] elapsed;
  logic signed [CW-1:0] flight_w;
  logic signed [CW-1:0] commit_w;
  logic adv_neg;
  logic flight_hit;
  logic commit_hit;

  assign kind       = classify(vld, done, unk);
  assign elapsed    = now - wb;
  assign flight_w   = zx_left(left) - sx_adv(adv);
  assign commit_w   = -sx_adv(adv) - zx_stamp(elapsed);
  assign adv_neg    = adv[ADV_W-1];
  assign flight_hit = (kind == KIND_FLIGHT) && (flight_w > 0);
  assign commit_hit = (kind == KIND_COMMIT) && adv_neg && (commit_w > 0);
  assign counts     = flight_hit || commit_hit;

  always_comb begin
    wait_cyc = '0;
    if (flight_hit)      wait_cyc = flight_w[WAIT_W-1:0];
    else if (commit_hit) wait_cyc = commit_w[WAIT_W-1:0];
  end

  AST_WAIT_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    counts |-> (wait_cyc != '0)); // R2

  AST_COMMIT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (counts && done) |-> adv[ADV_W-1]); // R7

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> !counts); // R10

endmodule

// File: rtl/raw_pick.sv
module raw_pick
  import raw_pkg::*;
#(
  parameter int NSRC   = 4,
  parameter int REG_W  = 6,
  parameter int WAIT_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  cand_kind_e              kind [NSRC],
  input  logic [NSRC-1:0]         counts,
  input  logic [NSRC*WAIT_W-1:0]  waits,
  input  logic [NSRC*REG_W-1:0]   regs,
  output logic                    pick_valid,
  output logic                    pick_unknown,
  output logic [REG_W-1:0]        pick_reg,
  output logic [WAIT_W-1:0]       pick_cyc
);
  always_comb begin
    pick_valid   = 1'b0;
    pick_unknown = 1'b0;
    pick_reg     = '0;
    pick_cyc     = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (kind[i] == KIND_UNKNOWN) begin
        if (!pick_valid) begin
          pick_valid   = 1'b1;
          pick_unknown = 1'b1;
          pick_reg     = regs[i*REG_W +: REG_W];
        end
      end else if (counts[i] && !pick_unknown &&
                   (waits[i*WAIT_W +: WAIT_W] > pick_cyc)) begin
        pick_valid = 1'b1;
        pick_reg   = regs[i*REG_W +: REG_W];
        pick_cyc   = waits[i*WAIT_W +: WAIT_W];
      end
    end
  end

  AST_UNK_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pick_unknown |-> pick_valid); // R5

  for (genvar g = 0; g < NSRC; g++) begin : g_max
    AST_PICK_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (counts[g] && !pick_unknown) |-> (waits[g*WAIT_W +: WAIT_W] <= pick_cyc)); // R3
  end

endmodule

// File: rtl/raw_wait_calc.sv
module raw_wait_calc
  import raw_pkg::*;
#(
  parameter int NSRC    = 4,
  parameter int LEFT_W  = 8,
  parameter int ADV_W   = 6,
  parameter int STAMP_W = 8,
  parameter int REG_W   = 6,
  localparam int WAIT_W = ((LEFT_W > ADV_W) ? LEFT_W : ADV_W) + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [NSRC-1:0]          cand_vld,
  input  logic [NSRC-1:0]          cand_done,
  input  logic [NSRC-1:0]          cand_unk,
  input  logic [NSRC*LEFT_W-1:0]   cand_left,
  input  logic [NSRC*STAMP_W-1:0]  cand_wb,
  input  logic [NSRC*ADV_W-1:0]    cand_adv,
  input  logic [NSRC*REG_W-1:0]    cand_reg,
  input  logic [STAMP_W-1:0]       now_cycle,
  output logic                     out_valid,
  output logic                     haz_valid,
  output logic                     haz_unknown,
  output logic [REG_W-1:0]         haz_reg,
  output logic [WAIT_W-1:0]        haz_cycles
);
  cand_kind_e              kind [NSRC];
  logic [NSRC-1:0]         counts;
  logic [NSRC*WAIT_W-1:0]  waits;
  logic                    pick_valid;
  logic                    pick_unknown;
  logic [REG_W-1:0]        pick_reg;
  logic [WAIT_W-1:0]       pick_cyc;

  for (genvar g = 0; g < NSRC; g++) begin : g_cand
    raw_cand_eval #(
      .LEFT_W(LEFT_W), .ADV_W(ADV_W), .STAMP_W(STAMP_W), .WAIT_W(WAIT_W)
    ) u_eval (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld      (cand_vld[g]),
      .done     (cand_done[g]),
      .unk      (cand_unk[g]),
      .left     (cand_left[g*LEFT_W +: LEFT_W]),
      .wb       (cand_wb[g*STAMP_W +: STAMP_W]),
      .adv      (cand_adv[g*ADV_W +: ADV_W]),
      .now      (now_cycle),
      .kind     (kind[g]),
      .counts   (counts[g]),
      .wait_cyc (waits[g*WAIT_W +: WAIT_W])
    );
  end

  raw_pick #(.NSRC(NSRC), .REG_W(REG_W), .WAIT_W(WAIT_W)) u_pick (
    .clk          (clk),
    .rst_n        (rst_n),
    .kind         (kind),
    .counts       (counts),
    .waits        (waits),
    .regs         (cand_reg),
    .pick_valid   (pick_valid),
    .pick_unknown (pick_unknown),
    .pick_reg     (pick_reg),
    .pick_cyc     (pick_cyc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      haz_valid   <= 1'b0;
      haz_unknown <= 1'b0;
      haz_reg     <= '0;
      haz_cycles  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        haz_valid   <= pick_valid;
        haz_unknown <= pick_unknown;
        haz_reg     <= pick_reg;
        haz_cycles  <= pick_cyc;
      end
    end
  end

  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R11

  AST_OUT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R11

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !haz_valid |-> (haz_cycles == '0 && haz_reg == '0)); // R10

  AST_UNK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    haz_unknown |-> (haz_valid && haz_cycles == '0)); // R5

endmodule

// File: tb/raw_wait_calc_test.sv
`timescale 1ns/1ps
module raw_wait_calc_test;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [N-1:0] cand_vld = '0, cand_done = '0, cand_unk = '0;
  logic [N*8-1:0] cand_left = '0, cand_wb = '0;
  logic [N*6-1:0] cand_adv = '0, cand_reg = '0;
  logic [7:0] now_cycle = '0;
  logic out_valid, haz_valid, haz_unknown;
  logic [5:0] haz_reg;
  logic [9:0] haz_cycles;

  always #4 clk = ~clk;

  raw_wait_calc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .cand_vld(cand_vld), .cand_done(cand_done), .cand_unk(cand_unk),
    .cand_left(cand_left), .cand_wb(cand_wb), .cand_adv(cand_adv),
    .cand_reg(cand_reg), .now_cycle(now_cycle),
    .out_valid(out_valid), .haz_valid(haz_valid), .haz_unknown(haz_unknown),
    .haz_reg(haz_reg), .haz_cycles(haz_cycles)
  );

  typedef struct {
    int hv; int hu; int rg; int cy; int due; string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int b_vld[N], b_done[N], b_unk[N], b_left[N], b_wb[N], b_adv[N], b_reg[N];
  int b_now;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      b_vld[i] = 0; b_done[i] = 0; b_unk[i] = 0; b_left[i] = 0;
      b_wb[i] = 0; b_adv[i] = 0; b_reg[i] = 0;
    end
    b_now = 0;
  endtask

  task automatic fl(int i, int left, int adv, int rg);
    b_vld[i] = 1; b_done[i] = 0; b_unk[i] = 0;
    b_left[i] = left; b_adv[i] = adv; b_reg[i] = rg;
  endtask

  task automatic cm(int i, int wb, int adv, int rg);
    b_vld[i] = 1; b_done[i] = 1; b_unk[i] = 0;
    b_wb[i] = wb; b_adv[i] = adv; b_reg[i] = rg;
  endtask

  task automatic uk(int i, int rg);
    b_vld[i] = 1; b_done[i] = 0; b_unk[i] = 1; b_reg[i] = rg;
  endtask

  function automatic exp_t model();
    exp_t e;
    int w, el;
    e.hv = 0; e.hu = 0; e.rg = 0; e.cy = 0;
    for (int i = 0; i < N; i++) begin
      if (b_vld[i] == 0) continue;
      if (b_done[i] == 0 && b_unk[i] != 0) begin
        if (e.hv == 0) begin e.hv = 1; e.hu = 1; e.rg = b_reg[i]; end
        continue;
      end
      if (b_done[i] == 0) w = b_left[i] - b_adv[i];
      else begin
        el = (b_now - b_wb[i] + 256) % 256;
        if (b_adv[i] >= 0 || el >= -b_adv[i]) continue;
        w = -b_adv[i] - el;
      end
      if (w > 0 && e.hu == 0 && w > e.cy) begin
        e.hv = 1; e.rg = b_reg[i]; e.cy = w;
      end
    end
    return e;
  endfunction

  task automatic send(string tag);
    exp_t e;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      cand_vld[i]        = b_vld[i][0];
      cand_done[i]       = b_done[i][0];
      cand_unk[i]        = b_unk[i][0];
      cand_left[i*8 +: 8] = b_left[i][7:0];
      cand_wb[i*8 +: 8]   = b_wb[i][7:0];
      cand_adv[i*6 +: 6]  = b_adv[i][5:0];
      cand_reg[i*6 +: 6]  = b_reg[i][5:0];
    end
    now_cycle = b_now[7:0];
    in_valid = 1'b1;
    e = model();
    e.due = cyc + 1;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
    clear_all();
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R11 unexpected out_valid actual=1 expected=0");
        end else begin
          e = q.pop_front();
          if (haz_valid !== e.hv[0] || haz_unknown !== e.hu[0] ||
              haz_reg !== e.rg[5:0] || haz_cycles !== e.cy[9:0]) begin
            errors++;
            $display("FAIL %s actual v=%0d u=%0d reg=%0d cyc=%0d expected v=%0d u=%0d reg=%0d cyc=%0d",
                     e.tag, haz_valid, haz_unknown, haz_reg, haz_cycles,
                     e.hv, e.hu, e.rg, e.cy);
          end
          checks++;
          if (cyc != e.due) begin
            errors++;
            $display("FAIL R11 result cycle actual=%0d expected=%0d", cyc, e.due);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(8ns * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    int lf;
    clear_all();
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || haz_valid !== 1'b0 || haz_cycles !== '0) begin
      errors++;
      $display("FAIL R11 reset actual ov=%0d hv=%0d cyc=%0d expected 0 0 0",
               out_valid, haz_valid, haz_cycles);
    end
    rst_n = 1'b1;

    fl(0, 5, 2, 3);                          send("R1 left-adv");
    fl(1, 3, -2, 7);                         send("R1 negative advance");
    fl(0, 2, 2, 1); fl(1, 1, 3, 2);          send("R2 non-positive");
    fl(0, 4, 0, 1); fl(1, 9, 1, 2); fl(2, 6, 0, 3); send("R3 largest");
    fl(1, 5, 0, 4); fl(3, 6, 1, 5);          send("R4 tie earlier");
    uk(2, 6);                                send("R5 unknown alone");
    fl(0, 4, 0, 1); uk(2, 6);                send("R5 unknown after known");
    cm(1, 0, 5, 9); b_unk[1] = 1; b_now = 1; send("R5 unk on committed");
    uk(0, 9); fl(1, 20, 0, 4);               send("R6 sticky unknown");
    uk(1, 11); uk(3, 12);                    send("R6 first unknown");
    cm(0, 5, 3, 2); cm(1, 5, 0, 3); b_now = 5; send("R7 non-negative");
    cm(0, 8, -4, 2); b_now = 10;             send("R8 committed wait");
    cm(0, 6, -4, 2); b_now = 10;             send("R8 window edge");
    cm(2, 7, -4, 5); b_now = 10;             send("R8 last cycle");
    cm(0, 254, -6, 8); b_now = 2;            send("R9 wrap");
    cm(0, 250, -6, 8); b_now = 2;            send("R9 wrap expired");
    b_left[0] = 200; b_reg[0] = 33; b_adv[1] = -20; b_done[1] = 1; send("R10 none valid");
    fl(0, 2, 0, 1); cm(1, 3, -8, 2); b_now = 4; send("R12 committed wins");
    cm(0, 9, -5, 7); fl(1, 4, 1, 8); b_now = 11; send("R12 tie committed first");
    fl(0, 30, -1, 3); cm(3, 0, -32, 4); b_now = 0; send("R12 extremes");

    lf = 32'h1ACE5;
    for (int k = 0; k < 60; k++) begin
      for (int i = 0; i < N; i++) begin
        lf = (lf << 1) ^ ((lf[31] ^ lf[21] ^ lf[1] ^ lf[0]) ? 1 : 0);
        b_vld[i]  = lf[0] | lf[9];
        b_done[i] = lf[1];
        b_unk[i]  = (lf[2] & lf[3] & lf[4]);
        b_left[i] = (lf >> 5) & 31;
        b_adv[i]  = ((lf >> 10) & 31) - 16;
        b_wb[i]   = (lf >> 16) & 255;
        b_reg[i]  = (lf >> 24) & 63;
      end
      b_now = (b_wb[0] + (lf & 15)) % 256;
      send("R3 R8 R12 sweep");
    end

    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R11 pending results actual=%0d expected=0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule